// File: doc/BRIEF.md
# OTP Memory Mode Decoder

This block is a synthesizable behavioural model of the control and data path of a one-time-programmable memory that can be read as 16-bit words or as bytes. Each cycle it decodes the operating mode from chip enable, output enable, a program strobe, a flag for programming voltage present and a flag for high voltage on address line 9. The mode is one of read, output disable, standby, program, program verify, program inhibit or auto-identify. The data outputs come with one enable for the low lane and one for the high lane. A disabled lane reads zero and stands for a floating bus.

The storage array starts in the erased state, with every bit at one. A program cycle can only clear bits. The write is committed when the program strobe rises after at least one cycle of valid program setup, and the new word is the old word ANDed with the input data. In byte mode the upper half of the word, or the lower half, is steered onto the low lane. Auto-identify returns fixed manufacturer and device codes to programming equipment.

Top module: `otp_mode_core`

## Requirements
- R1: With `ce_n` high, both lane enables are low and `dout` is zero, whatever `oe_n`, `hv_a9` or `vpp_hi` are.
- R2: With `ce_n` low, `oe_n` high and `vpp_hi` low (output disable), both lane enables are low and `dout` is zero.
- R3: A read (`ce_n`, `oe_n` and `vpp_hi` low, `word_sel` high) raises both lane enables, and `dout` is the stored word at index `addr[IDX_W-1:0]`.
- R4: In byte mode (`word_sel` low) the high lane enable is low and `dout[15:8]` is zero. With `a_m1` high, `dout[7:0]` carries stored bits 15..8. With `a_m1` low it carries stored bits 7..0.
- R5: After reset, every location reads 16'hFFFF.
- R6: Program setup is `ce_n` low, `oe_n` high, `pgm_n` low and `vpp_hi` high. During setup both lanes are off. At the first clock edge where `pgm_n` is sampled high, with `ce_n` low and `vpp_hi` high and program setup held at the edge before, the addressed word becomes old AND `din`. Other words are unchanged.
- R7: Programming never turns a stored 0 back into 1.
- R8: Program verify (`ce_n` low, `oe_n` low, `pgm_n` high, `vpp_hi` high) drives the stored word like a read.
- R9: With `vpp_hi` high and `ce_n` high (program inhibit), the outputs float and a strobe pulse changes no stored word.
- R10: In word mode, when `hv_a9` is high in a read, `addr[0]` low returns 16'h00C2 and `addr[0]` high returns 16'h0115, on both lanes.
- R11: In byte mode, auto-identify returns 8'hC2 (`addr[0]` low) or 8'h12 (`addr[0]` high) on the low lane only.
- R12: Auto-identify needs every address bit other than bits 0 and 9 low. Otherwise `hv_a9` is ignored and an ordinary read takes place.
- R13: A rising `pgm_n` that was not preceded by a cycle of program setup writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restores the erased state |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming voltage present |
| word_sel | input | 1 | 1 = word mode, 0 = byte mode |
| hv_a9 | input | 1 | High voltage present on address bit 9 |
| a_m1 | input | 1 | Byte half select in byte mode |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Program data |
| dout | output | DATA_W | Output data; zero on disabled lanes |
| lo_en | output | 1 | Low lane drive enable |
| hi_en | output | 1 | High lane drive enable |

## Verification
The mode decode, lane steering and identify codes are combinational from the inputs and the stored array. Their results are due in the same cycle as the stimulus, so the bench samples them two nanoseconds after the following rising edge, while the inputs are still held. A program commit lands on the edge at which the rising strobe is sampled. Its effect is therefore checked on the next table row, after one more edge. Each program sequence takes one setup row and one release row before the read-back row, so every stored-value check sits one edge after its commit.

// File: rtl/otp_pkg.sv
package otp_pkg;

   typedef enum logic [2:0] {
      M_STANDBY = 3'd0,
      M_OUTOFF  = 3'd1,
      M_READ    = 3'd2,
      M_PROG    = 3'd3,
      M_VERIFY  = 3'd4,
      M_INHIBIT = 3'd5,
      M_IDENT   = 3'd6
   } otp_mode_e;

   localparam logic [15:0] ID_MFR_WORD = 16'h00C2;
   localparam logic [15:0] ID_DEV_WORD = 16'h0115;
   localparam logic [7:0]  ID_MFR_BYTE = 8'hC2;
   localparam logic [7:0]  ID_DEV_BYTE = 8'h12;

   localparam int unsigned ID_HV_BIT = 9;

   function automatic logic mode_drives(input otp_mode_e m);
      return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
   endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
   import otp_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      pgm_n,
   input  logic      vpp_hi,
   input  logic      hv_a9,
   input  logic      id_ok,
   output otp_mode_e mode
);

   always_comb begin
      if (ce_n) begin
         mode = vpp_hi ? M_INHIBIT : M_STANDBY;
      end else if (vpp_hi) begin
         if (oe_n && !pgm_n)      mode = M_PROG;
         else if (!oe_n && pgm_n) mode = M_VERIFY;
         else                     mode = M_OUTOFF;
      end else if (oe_n) begin
         mode = M_OUTOFF;
      end else if (hv_a9 && id_ok) begin
         mode = M_IDENT;
      end else begin
         mode = M_READ;
      end
   end

endmodule

// File: rtl/otp_program_ctl.sv
module otp_program_ctl
   import otp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  otp_mode_e mode,
   input  logic      ce_n,
   input  logic      pgm_n,
   input  logic      vpp_hi,
   output logic      wr_en
);

   logic setup_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) setup_q <= 1'b0;
      else        setup_q <= (mode == M_PROG);
   end

   // commit on the first edge that sees the strobe released after setup
   assign wr_en = setup_q && pgm_n && !ce_n && vpp_hi;

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (wr_en) begin
         cells[idx] <= cells[idx] & wr_data;
      end
   end

   assign rd_data = cells[idx];

endmodule

// File: rtl/otp_lane_steer.sv
module otp_lane_steer
   import otp_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter bit          BYTE_CAPABLE = 1'b1,
   localparam int unsigned LANE_W      = DATA_W / 2
) (
   input  otp_mode_e         mode,
   input  logic              word_sel,
   input  logic              a_m1,
   input  logic              a0,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dout,
   output logic              lo_en,
   output logic              hi_en
);

   logic byte_mode;
   logic drive;
   logic [DATA_W-1:0] word_src;
   logic [LANE_W-1:0] byte_src;

   generate
      if (BYTE_CAPABLE) begin : g_byte
         assign byte_mode = !word_sel;
      end else begin : g_word_only
         assign byte_mode = 1'b0;
      end
   endgenerate

   assign drive = mode_drives(mode);

   always_comb begin
      if (mode == M_IDENT) word_src = a0 ? DATA_W'(ID_DEV_WORD) : DATA_W'(ID_MFR_WORD);
      else                 word_src = rd_data;
   end

   always_comb begin
      if (mode == M_IDENT) byte_src = a0 ? LANE_W'(ID_DEV_BYTE) : LANE_W'(ID_MFR_BYTE);
      else if (a_m1)       byte_src = rd_data[DATA_W-1:LANE_W];
      else                 byte_src = rd_data[LANE_W-1:0];
   end

   always_comb begin
      lo_en = drive;
      hi_en = drive && !byte_mode;
      if (!drive)         dout = '0;
      else if (byte_mode) dout = {{LANE_W{1'b0}}, byte_src};
      else                dout = word_src;
   end

endmodule

// File: rtl/otp_mode_core.sv
module otp_mode_core
   import otp_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DEPTH        = 256,
   parameter int unsigned DATA_W       = 16,
   parameter bit          BYTE_CAPABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              pgm_n,
   input  logic              vpp_hi,
   input  logic              word_sel,
   input  logic              hv_a9,
   input  logic              a_m1,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              lo_en,
   output logic              hi_en
);

   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [ADDR_W-1:0] ID_FREE_MASK =
      ~((ADDR_W'(1)) | (ADDR_W'(1) << ID_HV_BIT));

   generate
      if (ADDR_W <= ID_HV_BIT) begin : g_bad_addr
         $error("otp_mode_core: ADDR_W must exceed the identify bit index");
      end
      if (DEPTH < 2 || DEPTH > (64'd1 << ADDR_W)) begin : g_bad_depth
         $error("otp_mode_core: DEPTH out of range for ADDR_W");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("otp_mode_core: DEPTH must be a power of two");
      end
      if (DATA_W < 16 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("otp_mode_core: DATA_W must be even and at least 16");
      end
   endgenerate

   otp_mode_e        mode;
   logic             id_ok;
   logic             wr_en;
   logic [DATA_W-1:0] rd_data;

   assign id_ok = (addr & ID_FREE_MASK) == '0;

   otp_mode_decode u_decode (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .pgm_n  (pgm_n),
      .vpp_hi (vpp_hi),
      .hv_a9  (hv_a9),
      .id_ok  (id_ok),
      .mode   (mode)
   );

   otp_program_ctl u_prog (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .ce_n   (ce_n),
      .pgm_n  (pgm_n),
      .vpp_hi (vpp_hi),
      .wr_en  (wr_en)
   );

   otp_cell_array #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .idx     (addr[IDX_W-1:0]),
      .wr_data (din),
      .rd_data (rd_data)
   );

   otp_lane_steer #(
      .DATA_W       (DATA_W),
      .BYTE_CAPABLE (BYTE_CAPABLE)
   ) u_steer (
      .mode     (mode),
      .word_sel (word_sel),
      .a_m1     (a_m1),
      .a0       (addr[0]),
      .rd_data  (rd_data),
      .dout     (dout),
      .lo_en    (lo_en),
      .hi_en    (hi_en)
   );

endmodule

// File: rtl/otp_mode_core_chk.sv
module otp_mode_core_chk #(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 16,
   parameter bit          BYTE_CAPABLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              pgm_n,
   input logic              vpp_hi,
   input logic              word_sel,
   input logic              hv_a9,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] dout,
   input logic              lo_en,
   input logic              hi_en
);

   logic id_sel;
   assign id_sel = !ce_n && !oe_n && !vpp_hi && hv_a9 && word_sel &&
                   ((addr >> 1) == (ADDR_W'(1) << 8));

   // R1: deselected part never drives
   p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (!lo_en && !hi_en && dout == '0));

   // R2: output disable floats both lanes
   p_outoff_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n && !vpp_hi) |-> (!lo_en && !hi_en));

   // R4: high lane off in byte mode
   p_byte_hi_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (BYTE_CAPABLE && !word_sel) |-> (!hi_en && dout[DATA_W-1:DATA_W/2] == '0));

   // R6: outputs float during program setup
   p_prog_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n && !pgm_n && vpp_hi) |-> (!lo_en && !hi_en));

   // R8: verify drives both lanes in word mode
   p_verify_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && pgm_n && vpp_hi && word_sel) |-> (lo_en && hi_en));

   // R10: word identify codes
   p_ident_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
      id_sel |-> (lo_en && hi_en &&
                  dout == (addr[0] ? DATA_W'(16'h0115) : DATA_W'(16'h00C2))));

endmodule

bind otp_mode_core otp_mode_core_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .BYTE_CAPABLE (BYTE_CAPABLE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_n     (ce_n),
   .oe_n     (oe_n),
   .pgm_n    (pgm_n),
   .vpp_hi   (vpp_hi),
   .word_sel (word_sel),
   .hv_a9    (hv_a9),
   .addr     (addr),
   .dout     (dout),
   .lo_en    (lo_en),
   .hi_en    (hi_en)
);

// File: tb/otp_mode_core_bench.sv
module otp_mode_core_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0;
   logic        word_sel = 1'b1, hv_a9 = 1'b0, a_m1 = 1'b0;
   logic [15:0] addr = '0, din = '0;
   logic [15:0] dout;
   logic        lo_en, hi_en;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   otp_mode_core u_otp_mode_core (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
      .vpp_hi(vpp_hi), .word_sel(word_sel), .hv_a9(hv_a9), .a_m1(a_m1),
      .addr(addr), .din(din), .dout(dout), .lo_en(lo_en), .hi_en(hi_en)
   );

   typedef struct packed {
      logic        ce_n, oe_n, pgm_n, vpp, word, hv, am1;
      logic [15:0] addr, din;
      logic        lo, hi;
      logic [15:0] dout;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b1,1'b1,16'hFFFF,4'd5 }, // R5 erased
      '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b0,1'b0,16'h0000,4'd1 }, // R1
      '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b0,1'b0,16'h0000,4'd2 }, // R2
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,16'h0005,16'hA55A,1'b0,1'b0,16'h0000,4'd6 }, // R6 setup
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0005,16'hA55A,1'b0,1'b0,16'h0000,4'd6 }, // R6 commit
      '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b1,1'b1,16'hA55A,4'd8 }, // R8 verify
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b1,1'b1,16'hA55A,4'd3 }, // R3
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,16'h0005,16'h0000,1'b1,1'b0,16'h00A5,4'd4 }, // R4 upper
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0005,16'h0000,1'b1,1'b0,16'h005A,4'd4 }, // R4 lower
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,16'h0005,16'hFF0F,1'b0,1'b0,16'h0000,4'd7 }, // R7 setup
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0005,16'hFF0F,1'b0,1'b0,16'h0000,4'd7 }, // R7 commit
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b1,1'b1,16'hA50A,4'd7 }, // R7 AND
      '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b0,1'b0,16'h0000,4'd9 }, // R9
      '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b0,1'b0,16'h0000,4'd9 }, // R9
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b1,1'b1,16'hA50A,4'd9 }, // R9 kept
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,16'h0200,16'h0000,1'b1,1'b1,16'h00C2,4'd10}, // R10
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,16'h0201,16'h0000,1'b1,1'b1,16'h0115,4'd10}, // R10
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,16'h0200,16'h0000,1'b1,1'b0,16'h00C2,4'd11}, // R11
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,16'h0201,16'h0000,1'b1,1'b0,16'h0012,4'd11}, // R11
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,16'h0205,16'h0000,1'b1,1'b1,16'hA50A,4'd12}, // R12
      '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,16'h0007,16'h0000,1'b0,1'b0,16'h0000,4'd13}, // R13
      '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0007,16'h0000,1'b1,1'b1,16'hFFFF,4'd13}, // R13
      '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,16'h0200,16'h0000,1'b0,1'b0,16'h0000,4'd1 }  // R1 ident
   };

   task automatic check(input int req, input logic elo, input logic ehi,
                        input logic [15:0] ed);
      n_run++;
      if (lo_en !== elo || hi_en !== ehi || dout !== ed) begin
         n_fail++;
         $display("FAIL R%0d: got lo=%b hi=%b dout=%h, expected lo=%b hi=%b dout=%h",
                  req, lo_en, hi_en, dout, elo, ehi, ed);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      ce_n = v.ce_n; oe_n = v.oe_n; pgm_n = v.pgm_n; vpp_hi = v.vpp;
      word_sel = v.word; hv_a9 = v.hv; a_m1 = v.am1; addr = v.addr; din = v.din;
      @(posedge clk);
      #2;
      check(int'(v.req), v.lo, v.hi, v.dout);
   endtask

   function automatic vec_t mk(input logic c, input logic o, input logic p,
                               input logic vp, input logic [15:0] a,
                               input logic [15:0] d, input logic l, input logic h,
                               input logic [15:0] q, input logic [3:0] r);
      return '{c, o, p, vp, 1'b1, 1'b0, 1'b0, a, d, l, h, q, r};
   endfunction

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            #2;
            check(1, 1'b0, 1'b0, 16'h0000); // R1 during reset, chip deselected
            @(negedge clk);
            rst_n = 1'b1;
            for (int i = 0; i < NV; i++) apply(TBL[i]);
            // R6 boundary: last index, neighbour untouched
            apply(mk(1'b0,1'b1,1'b0,1'b1,16'h00FF,16'h1234,1'b0,1'b0,16'h0000,4'd6));
            apply(mk(1'b0,1'b1,1'b1,1'b1,16'h00FF,16'h1234,1'b0,1'b0,16'h0000,4'd6));
            apply(mk(1'b0,1'b0,1'b1,1'b0,16'h00FF,16'h0000,1'b1,1'b1,16'h1234,4'd6));
            apply(mk(1'b0,1'b0,1'b1,1'b0,16'h00FE,16'h0000,1'b1,1'b1,16'hFFFF,4'd6));
            // R5: reset restores the erased state
            @(negedge clk);
            ce_n = 1'b1;
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            apply(mk(1'b0,1'b0,1'b1,1'b0,16'h0005,16'h0000,1'b1,1'b1,16'hFFFF,4'd5));
            apply(mk(1'b0,1'b0,1'b1,1'b0,16'h00FF,16'h0000,1'b1,1'b1,16'hFFFF,4'd5));
            done = 1'b1;
         end
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               n_run++;
               n_fail++;
               $display("FAIL watchdog: got hung run, expected completion");
            end
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule